// File: doc/BRIEF.md
# Multi-Modulus Divide-by-2/3 Chain Divider

This block divides a fast clock by any integer from 1024 to 2047 and marks each divided period with a single-cycle pulse. It is the feedback divider of an integer-N synthesizer. For example, with a 1.568 GHz input and a ratio of 1568, the pulse rate is close to a 1 MHz reference. The ratio is not loaded into one wide down-counter. It comes from a cascade of ten identical cells. Each cell divides the tick rate it receives by two. When its program bit is set, it stretches one of its periods to three ticks, but only while the modulus signal from the next, slower cell is active.

Modulus signals travel backwards along the chain. The last cell's modulus input is tied active. Each cell passes the modulus on only while it is at the end of its own count. As a result, every cell takes its single long period at the same instant: the end of the full output period. The program bits therefore act only at that instant. A new ratio takes effect from the next complete period, so no period ever mixes two ratios.

The block is fully synchronous, with a single clock and an active-high synchronous reset. Each stage advances on a clock-enable tick from the stage before it. The pulse output is registered.

Top module: `mmd_divider`

## Requirements
- R1: `div_out` is high for exactly one clock cycle per divided period and is low in the cycle after each pulse.
- R2: Between consecutive `div_out` pulses there are exactly N = 1024 + `ratio_sel` clock cycles, with `ratio_sel` read as an unsigned 10-bit number, so every integer from 1024 to 2047 is reachable.
- R3: `ratio_sel` = 544 gives a period of 1568 clock cycles (a 1.568 GHz input yields about 1 MHz).
- R4: Bit i of `ratio_sel` adds 2^i cycles to the period. Bit 0 acts on the fastest cell and bit 9 on the slowest.
- R5: `ratio_sel` is read only at the clock edge that ends a period, which is the edge that raises `div_out`. A change at any other time leaves the current period at its old length and sets the length of the following period.
- R6: While `rst` is high, `div_out` is low. After the last clock edge with `rst` high, the first pulse appears exactly N edges later, with N taken from `ratio_sel` at that reset edge. A reset in mid-period discards the partial count.

Top module port order follows the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 10 | Ratio offset; period is 1024 plus this value |
| div_out | output | 1 | Registered one-cycle pulse per divided period |

## Verification
The ratio is tried at both ends of the range (0 and 1023), at the synthesizer's working value 544, at single set bits in the fastest and slowest cells, and at alternating bit patterns. A wrong cell-to-bit mapping, a missing swallow, or a swallow repeated more than once per period each give a different period for these patterns. Ratio changes are applied in mid-period and in the last cycle before a period ends. This separates sampling at the period boundary from sampling at any earlier time. Resets are applied both from idle and in mid-period, which shows that the first period is full length and that no stale count survives.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  // Per-cell phase counter: two flops hold 0..2 ticks remaining
  localparam int CNT_W = 2;
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t RELOAD_SHORT = cnt_t'(1); // divide-by-2 period
  localparam cnt_t RELOAD_LONG  = cnt_t'(2); // divide-by-3 period
  localparam cnt_t CNT_END      = cnt_t'(0);
endpackage

// File: rtl/mmd_cell.sv
module mmd_cell
  import mmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick_in,   // one input period of this cell
  input  logic mod_in,    // modulus request from the next (slower) cell
  input  logic prog,      // 1: allow one divide-by-3 period
  output logic tick_out,  // one output period of this cell
  output logic mod_out    // modulus request to the previous (faster) cell
);

  cnt_t cnt_q;
  logic at_end;
  logic go_long;

  assign at_end   = (cnt_q == CNT_END);
  assign tick_out = tick_in & at_end;
  assign mod_out  = mod_in & at_end;
  assign go_long  = prog & mod_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      // Reset acts as a global reload, so the first period is full length
      cnt_q <= prog ? RELOAD_LONG : RELOAD_SHORT;
    end else if (tick_in) begin
      if (at_end) cnt_q <= go_long ? RELOAD_LONG : RELOAD_SHORT;
      else        cnt_q <= cnt_q - cnt_t'(1);
    end
  end

  AST_CNT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cnt_q != cnt_t'(3)); // R2

  AST_CELL_GAP: assert property (@(posedge clk) disable iff (rst)
    tick_out |=> !tick_out); // R2

endmodule

// File: rtl/mmd_chain.sv
module mmd_chain #(
  parameter int NSTAGES = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSTAGES-1:0] prog,
  output logic               period_end
);

  logic [NSTAGES:0] tick;  // tick[i] drives cell i, tick[i+1] is its output
  logic [NSTAGES:0] modc;  // modc[i+1] enters cell i, modc[i] leaves it

  assign tick[0]       = 1'b1;
  assign modc[NSTAGES] = 1'b1;
  assign period_end    = tick[NSTAGES];

  for (genvar i = 0; i < NSTAGES; i++) begin : g_cell
    mmd_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .tick_in  (tick[i]),
      .mod_in   (modc[i+1]),
      .prog     (prog[i]),
      .tick_out (tick[i+1]),
      .mod_out  (modc[i])
    );

    // A stage may only take its long period at the end of the whole period
    AST_MOD_AT_END: assert property (@(posedge clk) disable iff (rst)
      (modc[i] && tick[i+1]) |-> period_end); // R5
  end

endmodule

// File: rtl/mmd_divider.sv
module mmd_divider #(
  parameter int NSTAGES = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSTAGES-1:0] ratio_sel,
  output logic               div_out
);

  localparam int N_BASE = 1 << NSTAGES;
  localparam int GAP_W  = NSTAGES + 2;

  logic period_end;

  mmd_chain #(.NSTAGES(NSTAGES)) u_chain (
    .clk        (clk),
    .rst        (rst),
    .prog       (ratio_sel),
    .period_end (period_end)
  );

  always_ff @(posedge clk) begin
    if (rst) div_out <= 1'b0;
    else     div_out <= period_end;
  end

  // Checker state: edges since the last reload and the ratio taken then
  logic [GAP_W-1:0] chk_gap;
  logic [GAP_W-1:0] chk_exp;

  always_ff @(posedge clk) begin
    if (rst || period_end) begin
      chk_gap <= '0;
      chk_exp <= GAP_W'(N_BASE) + GAP_W'(ratio_sel);
    end else begin
      chk_gap <= chk_gap + GAP_W'(1);
    end
  end

  AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (rst)
    period_end |-> (chk_gap == chk_exp - GAP_W'(1))); // R2

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    chk_gap < chk_exp); // R5

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out); // R1

endmodule

// File: tb/mmd_divider_tb.sv
`timescale 1ns/1ps
module mmd_divider_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] ratio_sel = '0;
  logic       div_out;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  always #4 clk = ~clk;

  mmd_divider #(.NSTAGES(10)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .ratio_sel (ratio_sel),
    .div_out   (div_out)
  );

  // ratio_sel values and the period the requirements give for each
  localparam int NVEC = 8;
  localparam int VEC_SEL [NVEC] = '{544, 0, 1023, 1, 512, 341, 682, 64};
  localparam int VEC_EXP [NVEC] = '{1568, 1024, 2047, 1025, 1536, 1365, 1706, 1088};
  // tags: 544 -> R3, single bits -> R4, others -> R2
  localparam int VEC_REQ [NVEC] = '{3, 2, 2, 4, 4, 2, 2, 4};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_reset(input logic [9:0] sel);
    @(negedge clk);
    rst = 1'b1;
    ratio_sel = sel;
    @(posedge clk);
    @(negedge clk);
    check("R6 div_out low in reset", int'(div_out), 0);
    rst = 1'b0;
  endtask

  // Count clock edges until div_out is seen high; optionally change ratio
  task automatic measure(input int chg_at, input logic [9:0] chg_val, output int gap);
    gap = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      gap++;
      if (gap == chg_at) ratio_sel = chg_val;
    end while (!div_out && gap < 4000);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<=190000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : main
    int g;
    // Vector table: first period after reset and one steady period
    for (int v = 0; v < NVEC; v++) begin
      apply_reset(10'(VEC_SEL[v]));
      measure(-1, '0, g);
      check("R6 first period", g, VEC_EXP[v]);
      measure(-1, '0, g);
      check($sformatf("R%0d steady period sel=%0d", VEC_REQ[v], VEC_SEL[v]), g, VEC_EXP[v]);
    end

    // R1: pulse lasts one cycle
    apply_reset(10'd5);
    measure(-1, '0, g);
    check("R1 pulse seen", int'(div_out), 1);
    @(posedge clk);
    @(negedge clk);
    check("R1 low after pulse", int'(div_out), 0);

    // R5: mid-period change applies from the next period
    apply_reset(10'd0);
    measure(-1, '0, g);
    check("R5 base period", g, 1024);
    measure(300, 10'd1023, g);
    check("R5 period with mid change", g, 1024);
    measure(-1, '0, g);
    check("R5 period after change", g, 2047);

    // R5: change in the last cycle before the period edge
    apply_reset(10'd512);
    measure(-1, '0, g);
    measure(1535, 10'd100, g);
    check("R5 late change current", g, 1536);
    measure(-1, '0, g);
    check("R5 late change next", g, 1124);

    // R6: reset in mid-period discards the partial count
    apply_reset(10'd700);
    repeat (500) @(posedge clk);
    apply_reset(10'd3);
    measure(-1, '0, g);
    check("R6 period after mid reset", g, 1027);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule